// File: doc/BRIEF.md
# Product-Term Logic Cell with Borrowed Terms

This block is one sum-of-products logic cell for a programmable-logic array. A small input bus feeds an AND plane that builds five local product terms. Each input enters a term in true or complemented form, or is left out of it. A select mask picks which local terms reach the cell's OR gate. A second mask lets the OR gate also take in up to fifteen product terms lent by the other cells of a sixteen-cell group, so the OR width grows when a function needs more terms. The local terms are also driven out, so that neighbouring cells can borrow them.

The OR result can leave the cell directly, or it can pass through a storage element. That element can act as a D, T, JK or SR flip-flop, or as a transparent latch. It has asynchronous set and clear inputs. Its clock is either the global clock or a clock built from one of the product terms. All configuration sits in a serial shift chain that loads while a load-enable input is high. During loading the cell drives only zeros.

Top module: `pterm_cell`

## Requirements
- R1: Product term k (k = 0..4) is the AND, over the inputs whose use bit is 1, of the input XOR its complement bit. A term with no use bits set evaluates to 1. `pt_out[k]` shows term k while loading is off.
- R2: The OR result is 1 when a local term with its select bit set is 1, or when a `share_in[j]` with its share-enable bit j set is 1. Terms that are not selected or not enabled have no effect.
- R3: With the bypass bit set, `cell_out` equals the OR result in the same cycle, with no clock edge in between.
- R4: In mode D (code 0) with the global clock, `cell_out` takes the OR result at each rising edge of `clk`.
- R5: In mode T (code 2) the stored value inverts at each edge where the OR result is 1, and holds otherwise.
- R6: In mode JK (code 1), term 3 is J and term 4 is K: 10 sets, 01 clears, 11 inverts and 00 holds.
- R7: In mode SR (code 3), term 3 is S and term 4 is R. S=1 sets, whatever R is. R=1 with S=0 clears, and 00 holds.
- R8: With the clock-select bit set, a flip-flop mode updates only at a global edge where term 2 is 1 and was 0 at the previous global edge.
- R9: In latch mode (code 4), `cell_out` follows the OR result while term 2 is 1, and holds the last value while term 2 is 0.
- R10: `aclr` forces the stored value and `cell_out` to 0 at once. It wins over `aset`. `aset` forces 1 and wins over any clock edge.
- R11: While `cfg_en` is 1, each rising edge shifts `cfg_sin` into chain bit 0 and every bit moves up one place. `cfg_sout` is the top bit. While `cfg_en` is 0 the chain holds. The chain has 10·N_IN+25 bits. The use bits of term k start at N_IN·k. The complement bits of term k start at 5·N_IN+N_IN·k. The five select bits start at 10·N_IN and the fifteen share enables at 10·N_IN+5. The 3-bit mode starts at 10·N_IN+20. Bypass is bit 10·N_IN+23 and clock select is bit 10·N_IN+24.
- R12: While `cfg_en` is 1, `cell_out` and `pt_out` are 0, and the stored value is cleared to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Global clock |
| rst_n | input | 1 | Active-low asynchronous reset of chain and storage |
| cfg_en | input | 1 | Configuration load enable |
| cfg_sin | input | 1 | Serial configuration data in |
| cfg_sout | output | 1 | Serial configuration data out (top chain bit) |
| in_bus | input | N_IN | Logic inputs to the AND plane |
| share_in | input | GROUP-1 | Product terms lent by neighbouring cells |
| aset | input | 1 | Asynchronous set of the storage element |
| aclr | input | 1 | Asynchronous clear of the storage element |
| pt_out | output | 5 | Local product terms, offered for borrowing |
| cell_out | output | 1 | Cell result to interconnect and I/O |

## Verification
The bench builds the cell with the default N_IN of 8 and GROUP of 16, which gives a 105-bit chain. This width is small enough to reload before every scenario. It is also large enough that the complemented, excluded and empty term cases, and a borrowed term at the middle of the share bus, can all be placed at once. Every reload also shifts the previous image out of `cfg_sout`, so the chain order is checked bit for bit. Each reload clears storage, so every storage mode starts from a known zero.

// File: rtl/ptcell_pkg.sv
package ptcell_pkg;

    localparam int PT_PER_CELL = 5;
    localparam int PT_CLK      = 2;
    localparam int PT_SJ       = 3;
    localparam int PT_RK       = 4;
    localparam int MODE_W      = 3;

    typedef enum logic [MODE_W-1:0] {
        ST_D     = 3'd0,
        ST_JK    = 3'd1,
        ST_T     = 3'd2,
        ST_SR    = 3'd3,
        ST_LATCH = 3'd4
    } store_mode_e;

    typedef struct packed {
        logic q;
        logic gate_prev;
    } store_t;

endpackage

// File: rtl/ptcell_cfg_chain.sv
module ptcell_cfg_chain #(
    parameter int W = 105
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_en,
    input  logic         cfg_sin,
    output logic [W-1:0] cfg_vec,
    output logic         cfg_sout
);
    logic [W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        if (cfg_en) begin
            chain_d = {chain_q[W-2:0], cfg_sin};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign cfg_vec  = chain_q;
    assign cfg_sout = chain_q[W-1];
endmodule

// File: rtl/ptcell_and_plane.sv
module ptcell_and_plane #(
    parameter int N_IN = 8,
    parameter int N_PT = 5
) (
    input  logic [N_IN-1:0]      in_bus,
    input  logic [N_PT*N_IN-1:0] use_bits,
    input  logic [N_PT*N_IN-1:0] inv_bits,
    output logic [N_PT-1:0]      terms
);
    for (genvar k = 0; k < N_PT; k++) begin : g_term
        logic [N_IN-1:0] lit;
        // excluded inputs contribute a 1 to the wired-AND
        assign lit      = ~use_bits[k*N_IN +: N_IN] | (in_bus ^ inv_bits[k*N_IN +: N_IN]);
        assign terms[k] = &lit;
    end
endmodule

// File: rtl/ptcell_or_gather.sv
module ptcell_or_gather #(
    parameter int N_PT    = 5,
    parameter int N_SHARE = 15
) (
    input  logic [N_PT-1:0]    terms,
    input  logic [N_PT-1:0]    sel,
    input  logic [N_SHARE-1:0] share_in,
    input  logic [N_SHARE-1:0] share_en,
    output logic               sum
);
    logic local_any;
    logic borrowed_any;

    assign local_any    = |(terms & sel);
    assign borrowed_any = |(share_in & share_en);
    assign sum          = local_any | borrowed_any;
endmodule

// File: rtl/ptcell_store.sv
module ptcell_store
    import ptcell_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        aset,
    input  logic        aclr,
    input  logic        hold_zero,
    input  store_mode_e mode,
    input  logic        clk_sel,
    input  logic        sum,
    input  logic        gate,
    input  logic        ctl_a,
    input  logic        ctl_b,
    output logic        q
);
    store_t st_d, st_q;
    logic   tick;

    always_comb begin
        tick         = clk_sel ? (gate & ~st_q.gate_prev) : 1'b1;
        st_d         = st_q;
        st_d.gate_prev = gate;
        unique case (mode)
            ST_JK: begin
                if (tick) begin
                    unique case ({ctl_a, ctl_b})
                        2'b10:   st_d.q = 1'b1;
                        2'b01:   st_d.q = 1'b0;
                        2'b11:   st_d.q = ~st_q.q;
                        default: st_d.q = st_q.q;
                    endcase
                end
            end
            ST_T: begin
                if (tick && sum) st_d.q = ~st_q.q;
            end
            ST_SR: begin
                if (tick) begin
                    if (ctl_a)      st_d.q = 1'b1;
                    else if (ctl_b) st_d.q = 1'b0;
                end
            end
            ST_LATCH: begin
                if (gate) st_d.q = sum;
            end
            default: begin
                if (tick) st_d.q = sum;
            end
        endcase
        if (hold_zero) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n or posedge aclr or posedge aset) begin
        if (!rst_n) begin
            st_q <= '0;
        end else if (aclr) begin
            st_q <= '0;
        end else if (aset) begin
            st_q <= '{q: 1'b1, gate_prev: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.q;
endmodule

// File: rtl/pterm_cell.sv
module pterm_cell
    import ptcell_pkg::*;
#(
    parameter int N_IN  = 8,
    parameter int GROUP = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_en,
    input  logic                   cfg_sin,
    output logic                   cfg_sout,
    input  logic [N_IN-1:0]        in_bus,
    input  logic [GROUP-2:0]       share_in,
    input  logic                   aset,
    input  logic                   aclr,
    output logic [PT_PER_CELL-1:0] pt_out,
    output logic                   cell_out
);
    localparam int N_PT     = PT_PER_CELL;
    localparam int N_SHARE  = GROUP - 1;
    localparam int PLANE_W  = N_PT * N_IN;
    localparam int USE_LO   = 0;
    localparam int INV_LO   = PLANE_W;
    localparam int SEL_LO   = 2 * PLANE_W;
    localparam int SH_LO    = SEL_LO + N_PT;
    localparam int MODE_LO  = SH_LO + N_SHARE;
    localparam int BYP_BIT  = MODE_LO + MODE_W;
    localparam int CSEL_BIT = BYP_BIT + 1;
    localparam int CFG_W    = CSEL_BIT + 1;

    logic [CFG_W-1:0]  cfg_vec;
    logic [N_PT-1:0]   terms;
    logic              or_sum;
    logic              q_store;
    logic              bypass;
    logic              clk_sel;
    store_mode_e       mode;
    logic              latch_view;
    logic              result;

    ptcell_cfg_chain #(.W(CFG_W)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_en   (cfg_en),
        .cfg_sin  (cfg_sin),
        .cfg_vec  (cfg_vec),
        .cfg_sout (cfg_sout)
    );

    assign bypass  = cfg_vec[BYP_BIT];
    assign clk_sel = cfg_vec[CSEL_BIT];
    assign mode    = store_mode_e'(cfg_vec[MODE_LO +: MODE_W]);

    ptcell_and_plane #(.N_IN(N_IN), .N_PT(N_PT)) u_plane (
        .in_bus   (in_bus),
        .use_bits (cfg_vec[USE_LO +: PLANE_W]),
        .inv_bits (cfg_vec[INV_LO +: PLANE_W]),
        .terms    (terms)
    );

    ptcell_or_gather #(.N_PT(N_PT), .N_SHARE(N_SHARE)) u_or (
        .terms    (terms),
        .sel      (cfg_vec[SEL_LO +: N_PT]),
        .share_in (share_in),
        .share_en (cfg_vec[SH_LO +: N_SHARE]),
        .sum      (or_sum)
    );

    ptcell_store u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .aset      (aset),
        .aclr      (aclr),
        .hold_zero (cfg_en),
        .mode      (mode),
        .clk_sel   (clk_sel),
        .sum       (or_sum),
        .gate      (terms[PT_CLK]),
        .ctl_a     (terms[PT_SJ]),
        .ctl_b     (terms[PT_RK]),
        .q         (q_store)
    );

    always_comb begin
        if (aclr)                latch_view = 1'b0;
        else if (aset)           latch_view = 1'b1;
        else if (terms[PT_CLK])  latch_view = or_sum;
        else                     latch_view = q_store;

        if (bypass)               result = or_sum;
        else if (mode == ST_LATCH) result = latch_view;
        else                      result = q_store;
    end

    assign cell_out = cfg_en ? 1'b0 : result;
    assign pt_out   = cfg_en ? '0 : terms;
endmodule

// File: rtl/ptcell_checker.sv
module ptcell_checker #(
    parameter int W    = 105,
    parameter int N_PT = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_en,
    input logic            cfg_sin,
    input logic [W-1:0]    cfg_vec,
    input logic            aset,
    input logic            aclr,
    input logic            bypass,
    input logic            clk_sel,
    input logic [2:0]      mode_bits,
    input logic            sum,
    input logic [N_PT-1:0] pt_out,
    input logic            cell_out
);
    a_r12_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |-> (cell_out == 1'b0 && pt_out == '0));

    a_r11_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> cfg_vec[0] == $past(cfg_sin));

    a_r11_retain: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> $stable(cfg_vec));

    a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (aclr && !cfg_en && !bypass) |-> cell_out == 1'b0);

    a_r3_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && bypass) |-> cell_out == sum);

    a_r4_d_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && !bypass && mode_bits == 3'd0 && !clk_sel && !aclr && !aset)
        |=> (cfg_en || aclr || aset || cell_out == $past(sum)));
endmodule

bind pterm_cell ptcell_checker #(.W(CFG_W), .N_PT(N_PT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_en    (cfg_en),
    .cfg_sin   (cfg_sin),
    .cfg_vec   (cfg_vec),
    .aset      (aset),
    .aclr      (aclr),
    .bypass    (bypass),
    .clk_sel   (clk_sel),
    .mode_bits (cfg_vec[MODE_LO +: MODE_W]),
    .sum       (or_sum),
    .pt_out    (pt_out),
    .cell_out  (cell_out)
);

// File: tb/pterm_cell_bench.sv
module pterm_cell_bench;
    localparam int CLK_P = 10;
    localparam int W     = 105;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b0;
    logic        cfg_sin = 1'b0;
    logic        cfg_sout;
    logic [7:0]  in_bus = '0;
    logic [14:0] share_in = '0;
    logic        aset = 1'b0;
    logic        aclr = 1'b0;
    logic [4:0]  pt_out;
    logic        cell_out;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic       exp_out;
        bit         chk_pt;
        logic [4:0] exp_pt;
        string      tag;
    } item_t;
    item_t sb[$];

    logic [W-1:0] prev_img = '0;

    always #(CLK_P/2) clk = ~clk;

    pterm_cell u_pterm_cell (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_sin(cfg_sin),
        .cfg_sout(cfg_sout), .in_bus(in_bus), .share_in(share_in),
        .aset(aset), .aclr(aclr), .pt_out(pt_out), .cell_out(cell_out)
    );

    // image builder from the R11 layout (N_IN = 8): term1 always empty
    function automatic logic [W-1:0] mk(
        input logic [7:0] u0, input logic [7:0] i0, input logic [7:0] u2,
        input logic [7:0] u3, input logic [7:0] u4, input logic [4:0] sel,
        input logic [14:0] sh, input logic [2:0] md, input logic byp, input logic cs);
        logic [W-1:0] v;
        v = '0;
        v[7:0]     = u0;
        v[23:16]   = u2;
        v[31:24]   = u3;
        v[39:32]   = u4;
        v[47:40]   = i0;
        v[84:80]   = sel;
        v[99:85]   = sh;
        v[102:100] = md;
        v[103]     = byp;
        v[104]     = cs;
        return v;
    endfunction

    task automatic push(input logic eo, input bit cp, input logic [4:0] ep, input string tag);
        item_t it;
        it.exp_out = eo; it.chk_pt = cp; it.exp_pt = ep; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic step(input logic [7:0] inv, input logic [14:0] sh, input logic s,
                        input logic c, input logic eo, input bit cp,
                        input logic [4:0] ep, input string tag);
        @(negedge clk);
        in_bus = inv; share_in = sh; aset = s; aclr = c;
        push(eo, cp, ep, tag);
    endtask

    // R11 R12: shift image in MSB first, compare what falls out of cfg_sout
    task automatic load(input logic [W-1:0] img);
        logic [W-1:0] seen;
        seen = '0;
        for (int i = W - 1; i >= 0; i--) begin
            @(negedge clk);
            seen[i] = cfg_sout;
            cfg_en  = 1'b1;
            cfg_sin = img[i];
            if (i == W / 2) begin
                in_bus = 8'hFF; share_in = '1;
                push(1'b0, 1'b1, 5'b00000, "R12 outputs held low while loading");
            end
        end
        @(negedge clk);
        cfg_en = 1'b0; cfg_sin = 1'b0; in_bus = '0; share_in = '0;
        checks++;
        if (seen !== prev_img) begin
            errors++;
            $display("FAIL R11 chain shift-out: got %h expected %h", seen, prev_img);
        end
        prev_img = img;
    endtask

    // monitor: one comparison per cycle, a quarter period after the edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_P/4);
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                checks++;
                if (cell_out !== it.exp_out) begin
                    errors++;
                    $display("FAIL %s: cell_out=%0b expected %0b", it.tag, cell_out, it.exp_out);
                end
                if (it.chk_pt) begin
                    checks++;
                    if (pt_out !== it.exp_pt) begin
                        errors++;
                        $display("FAIL %s: pt_out=%b expected %b", it.tag, pt_out, it.exp_pt);
                    end
                end
            end
        end
    end

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // reset state: all terms empty (R1) so pt_out is all ones, output 0
        step(8'h00, 15'h0, 0, 0, 1'b0, 1, 5'b11111, "R1 reset state");

        // R1 R3: term0 = in0 & ~in1, bypass
        load(mk(8'h03, 8'h02, 8'h00, 8'h00, 8'h00, 5'b00001, 15'h0, 3'd0, 1'b1, 1'b0));
        step(8'h01, 15'h0, 0, 0, 1'b1, 1, 5'b11111, "R3 bypass true");
        step(8'h03, 15'h0, 0, 0, 1'b0, 1, 5'b11110, "R1 complemented literal");
        step(8'h00, 15'h0, 0, 0, 1'b0, 1, 5'b11110, "R1 true literal");

        // R2: borrowed term 7 only, no local select
        load(mk(8'h03, 8'h02, 8'h00, 8'h00, 8'h00, 5'b00000, 15'h0080, 3'd0, 1'b1, 1'b0));
        step(8'h01, 15'h0080, 0, 0, 1'b1, 0, 5'b0, "R2 enabled borrowed term");
        step(8'h01, 15'h0040, 0, 0, 1'b0, 0, 5'b0, "R2 unselected local and borrowed ignored");
        step(8'h00, 15'h7F7F, 0, 0, 1'b0, 0, 5'b0, "R2 disabled borrowed terms ignored");

        // R4: D mode
        load(mk(8'h03, 8'h02, 8'h00, 8'h00, 8'h00, 5'b00001, 15'h0, 3'd0, 1'b0, 1'b0));
        step(8'h01, 15'h0, 0, 0, 1'b1, 0, 5'b0, "R4 D captures 1");
        step(8'h02, 15'h0, 0, 0, 1'b0, 0, 5'b0, "R4 D captures 0");

        // R10: async clear and set
        step(8'h01, 15'h0, 0, 0, 1'b1, 0, 5'b0, "R10 preset to 1");
        step(8'h01, 15'h0, 1, 1, 1'b0, 0, 5'b0, "R10 clear beats set");
        step(8'h00, 15'h0, 1, 0, 1'b1, 0, 5'b0, "R10 set beats clock");
        step(8'h00, 15'h0, 0, 0, 1'b0, 0, 5'b0, "R10 release set");
        step(8'h01, 15'h0, 0, 1, 1'b0, 0, 5'b0, "R10 clear beats clock");
        step(8'h01, 15'h0, 0, 0, 1'b1, 0, 5'b0, "R10 release clear");

        // R5: T mode
        load(mk(8'h03, 8'h02, 8'h00, 8'h00, 8'h00, 5'b00001, 15'h0, 3'd2, 1'b0, 1'b0));
        step(8'h01, 15'h0, 0, 0, 1'b1, 0, 5'b0, "R5 toggle up");
        step(8'h01, 15'h0, 0, 0, 1'b0, 0, 5'b0, "R5 toggle down");
        step(8'h00, 15'h0, 0, 0, 1'b0, 0, 5'b0, "R5 hold");
        step(8'h01, 15'h0, 0, 0, 1'b1, 0, 5'b0, "R5 toggle again");

        // R6: JK, J = in2 (term3), K = in3 (term4)
        load(mk(8'h00, 8'h00, 8'h00, 8'h04, 8'h08, 5'b00000, 15'h0, 3'd1, 1'b0, 1'b0));
        step(8'h04, 15'h0, 0, 0, 1'b1, 0, 5'b0, "R6 J sets");
        step(8'h00, 15'h0, 0, 0, 1'b1, 0, 5'b0, "R6 hold");
        step(8'h0C, 15'h0, 0, 0, 1'b0, 0, 5'b0, "R6 toggle down");
        step(8'h0C, 15'h0, 0, 0, 1'b1, 0, 5'b0, "R6 toggle up");
        step(8'h08, 15'h0, 0, 0, 1'b0, 0, 5'b0, "R6 K clears");

        // R7: SR with same term roles
        load(mk(8'h00, 8'h00, 8'h00, 8'h04, 8'h08, 5'b00000, 15'h0, 3'd3, 1'b0, 1'b0));
        step(8'h0C, 15'h0, 0, 0, 1'b1, 0, 5'b0, "R7 S=R=1 sets");
        step(8'h08, 15'h0, 0, 0, 1'b0, 0, 5'b0, "R7 R clears");
        step(8'h04, 15'h0, 0, 0, 1'b1, 0, 5'b0, "R7 S sets");
        step(8'h00, 15'h0, 0, 0, 1'b1, 0, 5'b0, "R7 hold");

        // R8: product-term clock, term2 = in4
        load(mk(8'h03, 8'h02, 8'h10, 8'h00, 8'h00, 5'b00001, 15'h0, 3'd0, 1'b0, 1'b1));
        step(8'h01, 15'h0, 0, 0, 1'b0, 0, 5'b0, "R8 no rising term, no update");
        step(8'h11, 15'h0, 0, 0, 1'b1, 0, 5'b0, "R8 rising term captures");
        step(8'h10, 15'h0, 0, 0, 1'b1, 0, 5'b0, "R8 term held high, no update");
        step(8'h00, 15'h0, 0, 0, 1'b1, 0, 5'b0, "R8 falling term, no update");
        step(8'h10, 15'h0, 0, 0, 1'b0, 0, 5'b0, "R8 second rise captures 0");

        // R9: latch, gate = term2 = in4
        load(mk(8'h03, 8'h02, 8'h10, 8'h00, 8'h00, 5'b00001, 15'h0, 3'd4, 1'b0, 1'b0));
        step(8'h11, 15'h0, 0, 0, 1'b1, 0, 5'b0, "R9 transparent 1");
        step(8'h01, 15'h0, 0, 0, 1'b1, 0, 5'b0, "R9 gate low holds");
        step(8'h00, 15'h0, 0, 0, 1'b1, 0, 5'b0, "R9 gate low holds on input change");
        step(8'h10, 15'h0, 0, 0, 1'b0, 0, 5'b0, "R9 transparent 0");

        // final reload checks the last image on the chain output
        load(mk(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 5'b00000, 15'h0, 3'd0, 1'b0, 1'b0));
        step(8'h00, 15'h0, 0, 0, 1'b0, 1, 5'b11111, "R11 cleared image");

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule